// File: doc/BRIEF.md
# HDLC Transmit Bit Serializer

This block turns a stream of packet bytes, each tagged with an end-of-packet marker, into the single-bit line signal of one HDLC channel. Bytes arrive over a valid/ready handshake. The block shifts each byte out one bit per active cycle of an external bit-enable strobe. It inserts a zero after every run of five ones inside packet content. When the checksum is enabled, it appends a 16-bit frame check sequence. It sends the flag octet 01111110 between packets and whenever no byte is waiting. Three configuration inputs control the line format: bit order within each data byte, whether the checksum is appended, and whether the line is inverted as the very last stage.

The serializer is built around a three-state machine. `ST_FLAG` shifts out a flag octet. On its last bit it either accepts the first byte of a packet and moves to `ST_DATA`, or reloads another flag. `ST_DATA` shifts out data bytes. On the last bit of a byte it accepts the next byte and stays. If the byte was end-tagged, or no byte is offered, it moves to `ST_FCS` when the checksum is enabled and to `ST_FLAG` otherwise. `ST_FCS` shifts out the 16 checksum bits and then returns to `ST_FLAG`. A stuffed zero holds the state machine for one strobe without advancing it.

The output stage registers each line bit together with a strobe, so `tx_bit_en` marks the cycle after every active `bit_en`.

Top module: `hdlc_tx_serializer`

## Requirements
- R1: While `rst_n` is low, `tx_bit`, `tx_bit_en` and `in_ready` are all 0.
- R2: With no byte offered, the line carries back-to-back flag octets 0,1,1,1,1,1,1,0 in sending order, and no zero is ever inserted into a flag.
- R3: With `cfg_msb_first` = 0, each data byte is sent starting at bit 0 and ending at bit 7.
- R4: With `cfg_msb_first` = 1, each data byte is sent starting at bit 7 and ending at bit 0.
- R5: With `cfg_fcs_off` = 0, the ones' complement of a CRC-16 is sent after the last data byte. The CRC uses generator x^16+x^12+x^5+1, starts at all ones, and runs over the data bits in the order they are sent. Its low-order bit goes first whatever the byte order. A receiver running the same CRC over data and checksum ends with residue 0xF0B8.
- R6: With `cfg_fcs_off` = 1, the closing flag follows the last data bit directly.
- R7: After five consecutive ones within data or checksum bits, one 0 is sent before the next content bit, including just before the closing flag.
- R8: With inversion active, every line bit, flags and stuffed zeros included, is the complement of the uninverted bit.
- R9: Byte order and checksum enable are sampled when the first byte of a packet is accepted. Inversion is sampled only when an idle flag is loaded after a flag. A change of any of them during a packet, including its closing flag, has no effect on that packet.
- R10: `in_ready` is high only in a cycle with `bit_en` high, when the last bit of a flag or of a non-end data byte is being sent. It is never high during a stuffed zero, so an idle line raises it once per eight strobes.
- R11: `tx_bit_en` is high exactly in the cycle after each cycle with `bit_en` high.
- R12: If no byte is offered when a non-end data byte finishes, the packet is closed as if that byte had been end-tagged, with the checksum appended when enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit-time strobe; one line bit per active cycle |
| in_data | input | 8 | Packet byte offered by the source |
| in_end | input | 1 | Marks `in_data` as the last byte of its packet |
| in_valid | input | 1 | Source offers a byte |
| in_ready | output | 1 | Byte accepted this cycle when `in_valid` is also high |
| cfg_invert | input | 1 | 1 inverts the line output |
| cfg_fcs_off | input | 1 | 1 suppresses the checksum |
| cfg_msb_first | input | 1 | 1 sends bit 7 of each data byte first |
| tx_bit | output | 1 | Serial line bit |
| tx_bit_en | output | 1 | High when `tx_bit` carries a new bit |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, a 16-bit checksum and a five-ones stuffing run. With these values every bit position of a byte, the full checksum and the residue check can be reached. Bytes such as 0xFF and 0x7E then force stuffing inside data, across byte edges and at the tail of the checksum. The strobe divider is varied (every cycle, every second, every third cycle), so that handshake timing, idle flag cadence and mid-packet configuration changes are exercised at several bit rates.

// File: rtl/hdlc_tx_pkg.sv
`timescale 1ns/1ps
package hdlc_tx_pkg;

    typedef enum logic [1:0] {
        ST_FLAG = 2'd0,
        ST_DATA = 2'd1,
        ST_FCS  = 2'd2
    } tx_state_e;

endpackage

// File: rtl/hdlc_tx_crc.sv
`timescale 1ns/1ps
module hdlc_tx_crc #(
    parameter int           W    = 16,
    parameter logic [W-1:0] POLY = 16'h8408,
    parameter logic [W-1:0] INIT = 16'hFFFF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic upd,
    input  logic shift,
    input  logic din,
    output logic fcs_bit
);

    logic [W-1:0] crc_q;
    logic         fb;

    assign fb = crc_q[0] ^ din;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= INIT;
        end else if (clr) begin
            crc_q <= INIT;
        end else if (upd) begin
            crc_q <= (crc_q >> 1) ^ (fb ? POLY : '0);
        end else if (shift) begin
            crc_q <= crc_q >> 1;
        end
    end

    assign fcs_bit = ~crc_q[0];

endmodule

// File: rtl/hdlc_tx_stuffer.sv
`timescale 1ns/1ps
module hdlc_tx_stuffer #(
    parameter int RUN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic cur,
    input  logic stuffable,
    output logic insert
);

    localparam int RUN_W = $clog2(RUN + 1);

    logic [RUN_W-1:0] ones_q;

    assign insert = (ones_q == RUN_W'(RUN));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ones_q <= '0;
        end else if (bit_en) begin
            if (insert) begin
                ones_q <= '0;
            end else if (stuffable && cur) begin
                ones_q <= ones_q + RUN_W'(1);
            end else begin
                ones_q <= '0;
            end
        end
    end

    AST_RUN_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && insert) |=> (ones_q == '0)) else $error("stuff run not cleared"); // R7

endmodule

// File: rtl/hdlc_tx_outstage.sv
`timescale 1ns/1ps
module hdlc_tx_outstage (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic line_bit,
    input  logic invert,
    output logic tx_bit,
    output logic tx_bit_en
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_bit    <= 1'b0;
            tx_bit_en <= 1'b0;
        end else begin
            tx_bit_en <= bit_en;
            if (bit_en) begin
                tx_bit <= line_bit ^ invert;
            end
        end
    end

    AST_QUIET_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(tx_bit)) else $error("line bit moved without strobe"); // R11

endmodule

// File: rtl/hdlc_tx_serializer.sv
`timescale 1ns/1ps
module hdlc_tx_serializer
    import hdlc_tx_pkg::*;
#(
    parameter int                DATA_W       = 8,
    parameter int                CRC_W        = 16,
    parameter logic [CRC_W-1:0]  CRC_POLY     = 16'h8408,
    parameter logic [CRC_W-1:0]  CRC_INIT     = 16'hFFFF,
    parameter int                STUFF_RUN    = 5,
    parameter logic [DATA_W-1:0] FLAG_PATTERN = 8'h7E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_end,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              cfg_invert,
    input  logic              cfg_fcs_off,
    input  logic              cfg_msb_first,
    output logic              tx_bit,
    output logic              tx_bit_en
);

    localparam int CNT_W  = $clog2(DATA_W);
    localparam int FCNT_W = $clog2(CRC_W);

    tx_state_e         state_q;
    tx_state_e         state_d;
    logic [DATA_W-1:0] sh_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [FCNT_W-1:0] fcnt_q;
    logic              end_q;
    logic              msb_q;
    logic              fcsoff_q;
    logic              inv_q;

    logic insert;
    logic fcs_bit;
    logic cur_bit;
    logic line_bit;
    logic adv;
    logic at_last;
    logic take;
    logic stuffable;

    // ---------------- bit selection and handshake ----------------
    always_comb begin
        unique case (state_q)
            ST_FLAG: cur_bit = sh_q[0];
            ST_DATA: cur_bit = msb_q ? sh_q[DATA_W-1] : sh_q[0];
            ST_FCS:  cur_bit = fcs_bit;
            default: cur_bit = 1'b1;
        endcase
    end

    assign stuffable = (state_q != ST_FLAG);
    assign line_bit  = insert ? 1'b0 : cur_bit;
    assign adv       = bit_en && !insert;
    assign at_last   = (state_q == ST_FCS) ? (fcnt_q == FCNT_W'(CRC_W - 1))
                                           : (cnt_q == CNT_W'(DATA_W - 1));
    assign in_ready  = adv && at_last &&
                       ((state_q == ST_FLAG) || ((state_q == ST_DATA) && !end_q));
    assign take      = in_ready && in_valid;

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        if (adv && at_last) begin
            unique case (state_q)
                ST_FLAG: if (take) state_d = ST_DATA;
                ST_DATA: if (!take) state_d = fcsoff_q ? ST_FLAG : ST_FCS;
                ST_FCS:  state_d = ST_FLAG;
                default: state_d = ST_FLAG;
            endcase
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FLAG;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- shift register, counters, sampled controls ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q     <= FLAG_PATTERN;
            cnt_q    <= '0;
            fcnt_q   <= '0;
            end_q    <= 1'b0;
            msb_q    <= 1'b0;
            fcsoff_q <= 1'b0;
            inv_q    <= 1'b0;
        end else if (adv) begin
            if (at_last) begin
                cnt_q  <= '0;
                fcnt_q <= '0;
                if (take) begin
                    sh_q  <= in_data;
                    end_q <= in_end;
                    if (state_q == ST_FLAG) begin
                        msb_q    <= cfg_msb_first;
                        fcsoff_q <= cfg_fcs_off;
                    end
                end else begin
                    sh_q <= FLAG_PATTERN;
                    if (state_q == ST_FLAG) begin
                        inv_q <= cfg_invert;
                    end
                end
            end else begin
                if (state_q == ST_FCS) begin
                    fcnt_q <= fcnt_q + FCNT_W'(1);
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
                if ((state_q == ST_DATA) && msb_q) begin
                    sh_q <= sh_q << 1;
                end else begin
                    sh_q <= sh_q >> 1;
                end
            end
        end
    end

    // ---------------- sub-blocks ----------------
    hdlc_tx_crc #(
        .W    (CRC_W),
        .POLY (CRC_POLY),
        .INIT (CRC_INIT)
    ) u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (take && (state_q == ST_FLAG)),
        .upd     (adv && (state_q == ST_DATA)),
        .shift   (adv && (state_q == ST_FCS)),
        .din     (cur_bit),
        .fcs_bit (fcs_bit)
    );

    hdlc_tx_stuffer #(
        .RUN (STUFF_RUN)
    ) u_stuff (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .cur       (cur_bit),
        .stuffable (stuffable),
        .insert    (insert)
    );

    hdlc_tx_outstage u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .line_bit  (line_bit),
        .invert    (inv_q),
        .tx_bit    (tx_bit),
        .tx_bit_en (tx_bit_en)
    );

    // ---------------- assertions ----------------
    AST_STUFF_EMITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && insert) |=> (tx_bit == $past(inv_q))) else $error("stuffed bit not zero"); // R7

    AST_CFG_HELD_IN_PACKET: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_DATA) && ($past(state_q) == ST_DATA)) |-> ($stable(msb_q) && $stable(fcsoff_q) && $stable(inv_q)))
        else $error("control changed inside packet"); // R9

    AST_FCS_ONLY_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_FCS) |-> (($past(state_q) == ST_DATA) && !fcsoff_q)) else $error("bad checksum entry"); // R5

    AST_NO_FCS_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FCS) |-> !fcsoff_q) else $error("checksum sent while disabled"); // R6

    AST_READY_STROBED_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> tx_bit_en) else $error("ready without line strobe"); // R10

    AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en |=> tx_bit_en) else $error("line strobe missing"); // R11

endmodule

// File: tb/hdlc_tx_serializer_tb.sv
`timescale 1ns/1ps
module hdlc_tx_serializer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_end = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic       cfg_invert = 1'b0;
    logic       cfg_fcs_off = 1'b0;
    logic       cfg_msb_first = 1'b0;
    logic       tx_bit;
    logic       tx_bit_en;

    always #10 clk = ~clk;

    hdlc_tx_serializer u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .bit_en        (bit_en),
        .in_data       (in_data),
        .in_end        (in_end),
        .in_valid      (in_valid),
        .in_ready      (in_ready),
        .cfg_invert    (cfg_invert),
        .cfg_fcs_off   (cfg_fcs_off),
        .cfg_msb_first (cfg_msb_first),
        .tx_bit        (tx_bit),
        .tx_bit_en     (tx_bit_en)
    );

    int n_chk = 0;
    int n_bad = 0;

    // source
    logic [7:0] src_d[$];
    logic       src_e[$];
    logic       took = 1'b0;
    int         strobe_div = 1;
    int         cyc = 0;

    // receiver
    logic rx_pol = 1'b0;
    int   ones = 0;
    logic rbits[$];
    int   stuffcnt = 0;
    logic synced = 1'b0;
    logic fbits[$];
    int   fstuff = 0;
    int   fcount = 0;
    logic cap = 1'b0;
    logic rawq[$];

    // handshake / strobe monitors
    logic mon = 1'b0;
    logic last_drv = 1'b0;
    int   ready_cnt = 0;
    int   strobe_cnt = 0;
    int   ready_bad = 0;
    int   follow_bad = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rx_bit(input logic b);
        if (b) begin
            ones++;
            rbits.push_back(1'b1);
        end else begin
            if (ones == 5) begin
                stuffcnt++;
            end else if (ones == 6) begin
                if (synced && rbits.size() > 7) begin
                    fbits.delete();
                    for (int i = 0; i < rbits.size() - 7; i++) fbits.push_back(rbits[i]);
                    fstuff = stuffcnt;
                    fcount++;
                end
                synced = 1'b1;
                rbits.delete();
                stuffcnt = 0;
            end else begin
                rbits.push_back(1'b0);
            end
            ones = 0;
        end
    endtask

    task automatic step();
        @(negedge clk);
        cyc++;
        if (mon && (tx_bit_en !== last_drv)) follow_bad++;
        if (tx_bit_en) begin
            if (cap) rawq.push_back(tx_bit);
            rx_bit(tx_bit ^ rx_pol);
        end
        if (took) begin
            void'(src_d.pop_front());
            void'(src_e.pop_front());
        end
        bit_en   = (strobe_div <= 1) ? 1'b1 : ((cyc % strobe_div) == 0);
        in_valid = rst_n && (src_d.size() > 0);
        in_data  = (src_d.size() > 0) ? src_d[0] : 8'h00;
        in_end   = (src_e.size() > 0) ? src_e[0] : 1'b0;
        last_drv = bit_en;
        #1;
        took = in_valid && in_ready;
        if (mon) begin
            if (in_ready) ready_cnt++;
            if (bit_en) strobe_cnt++;
            if (in_ready && !bit_en) ready_bad++;
        end
    endtask

    task automatic do_reset(input logic inv, input logic foff, input logic msb, input int div);
        rst_n = 1'b0;
        cfg_invert = inv;
        cfg_fcs_off = foff;
        cfg_msb_first = msb;
        strobe_div = div;
        src_d.delete();
        src_e.delete();
        took = 1'b0;
        rx_pol = inv;
        ones = 0;
        rbits.delete();
        synced = 1'b0;
        stuffcnt = 0;
        mon = 1'b0;
        cap = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        repeat (40 * div) step();
    endtask

    task automatic push_pkt(input logic [7:0] b[$], input logic end_last);
        foreach (b[i]) begin
            src_d.push_back(b[i]);
            src_e.push_back((i == b.size() - 1) ? end_last : 1'b0);
        end
    endtask

    task automatic expect_frame(input logic [7:0] exp[$], input logic msb, input logic fcs, input string req);
        int start;
        int guard;
        int nbits;
        int bad;
        int run;
        int xs;
        logic [15:0] c;
        logic fb;
        start = fcount;
        guard = 0;
        while (fcount == start && guard < 4000) begin
            step();
            guard++;
        end
        chk(fcount != start, {req, " frame received"}, fcount - start, 1);
        if (fcount == start) return;
        nbits = exp.size() * 8 + (fcs ? 16 : 0);
        chk(fbits.size() == nbits, {req, " frame length in bits"}, fbits.size(), nbits);
        if (fbits.size() != nbits) return;
        bad = 0;
        foreach (exp[i]) begin
            logic [7:0] v;
            for (int k = 0; k < 8; k++) begin
                if (msb) v[7 - k] = fbits[8 * i + k];
                else     v[k]     = fbits[8 * i + k];
            end
            if (v !== exp[i]) begin
                bad++;
                chk(1'b0, {req, " data byte"}, v, exp[i]);
            end
        end
        if (bad == 0) chk(1'b1, {req, " data bytes"}, 0, 0);
        if (fcs) begin
            c = 16'hFFFF;
            foreach (fbits[i]) begin
                fb = c[0] ^ fbits[i];
                c = c >> 1;
                if (fb) c = c ^ 16'h8408;
            end
            chk(c == 16'hF0B8, "R5 checksum residue", c, 16'hF0B8);
        end
        run = 0;
        xs = 0;
        foreach (fbits[i]) begin
            if (fbits[i]) begin
                run++;
                if (run == 5) begin
                    xs++;
                    run = 0;
                end
            end else begin
                run = 0;
            end
        end
        chk(fstuff == xs, "R7 stuffed zero count", fstuff, xs);
    endtask

    function automatic int flag_mismatch(input logic pol);
        int best;
        best = 999;
        for (int a = 0; a < 8; a++) begin
            int m;
            m = 0;
            for (int j = 0; j < 32; j++) begin
                logic e;
                e = (((j % 8) == 0) || ((j % 8) == 7)) ? 1'b0 : 1'b1;
                if ((rawq[a + j] ^ pol) !== e) m++;
            end
            if (m < best) best = m;
        end
        return best;
    endfunction

    // ---------------- scenarios ----------------
    task automatic t_reset();
        rst_n = 1'b0;
        strobe_div = 1;
        repeat (4) step();
        chk(tx_bit_en == 1'b0, "R1 tx_bit_en in reset", tx_bit_en, 0);
        chk(tx_bit == 1'b0, "R1 tx_bit in reset", tx_bit, 0);
        chk(in_ready == 1'b0, "R1 in_ready in reset", in_ready, 0);
    endtask

    task automatic t_idle_flags();
        do_reset(1'b0, 1'b0, 1'b0, 1);
        rawq.delete();
        cap = 1'b1;
        repeat (48) step();
        cap = 1'b0;
        chk(flag_mismatch(1'b0) == 0, "R2 idle flag pattern", flag_mismatch(1'b0), 0);
    endtask

    task automatic t_lsb_fcs();
        do_reset(1'b0, 1'b0, 1'b0, 1);
        push_pkt('{8'hA5, 8'h3C, 8'h01}, 1'b1);
        expect_frame('{8'hA5, 8'h3C, 8'h01}, 1'b0, 1'b1, "R3 lsb-first");
    endtask

    task automatic t_msb_fcs();
        do_reset(1'b0, 1'b0, 1'b1, 3);
        push_pkt('{8'hA5, 8'hC3, 8'h80}, 1'b1);
        expect_frame('{8'hA5, 8'hC3, 8'h80}, 1'b1, 1'b1, "R4 msb-first");
    endtask

    task automatic t_fcs_off();
        do_reset(1'b0, 1'b1, 1'b0, 2);
        push_pkt('{8'h12, 8'h34}, 1'b1);
        expect_frame('{8'h12, 8'h34}, 1'b0, 1'b0, "R6 no checksum");
    endtask

    task automatic t_stuff();
        do_reset(1'b0, 1'b0, 1'b0, 1);
        push_pkt('{8'hFF, 8'hFF, 8'h7E, 8'hF8}, 1'b1);
        expect_frame('{8'hFF, 8'hFF, 8'h7E, 8'hF8}, 1'b0, 1'b1, "R7 stuffing");
        chk(fstuff >= 4, "R7 stuffing happened", fstuff, 4);
    endtask

    task automatic t_invert();
        do_reset(1'b1, 1'b0, 1'b0, 2);
        rawq.delete();
        cap = 1'b1;
        repeat (96) step();
        cap = 1'b0;
        chk(flag_mismatch(1'b1) == 0, "R8 inverted idle flags", flag_mismatch(1'b1), 0);
        push_pkt('{8'h55, 8'hAA, 8'hFF}, 1'b1);
        expect_frame('{8'h55, 8'hAA, 8'hFF}, 1'b0, 1'b1, "R8 inverted packet");
    endtask

    task automatic t_midchange();
        int guard;
        do_reset(1'b0, 1'b0, 1'b0, 2);
        push_pkt('{8'hC1, 8'h0F, 8'h9A, 8'h44}, 1'b1);
        guard = 0;
        while (src_d.size() >= 4 && guard < 1000) begin
            step();
            guard++;
        end
        cfg_msb_first = 1'b1;
        cfg_fcs_off = 1'b1;
        cfg_invert = 1'b1;
        expect_frame('{8'hC1, 8'h0F, 8'h9A, 8'h44}, 1'b0, 1'b1, "R9 mid-packet change");
    endtask

    task automatic t_underrun();
        do_reset(1'b0, 1'b0, 1'b0, 1);
        push_pkt('{8'h11, 8'h22}, 1'b0);
        expect_frame('{8'h11, 8'h22}, 1'b0, 1'b1, "R12 underrun close");
    endtask

    task automatic t_handshake();
        do_reset(1'b0, 1'b0, 1'b0, 2);
        step();
        ready_cnt = 0;
        strobe_cnt = 0;
        ready_bad = 0;
        follow_bad = 0;
        mon = 1'b1;
        repeat (160) step();
        mon = 1'b0;
        chk(ready_cnt == strobe_cnt / 8, "R10 idle ready cadence", ready_cnt, strobe_cnt / 8);
        chk(ready_bad == 0, "R10 ready without strobe", ready_bad, 0);
        chk(follow_bad == 0, "R11 line strobe follows bit_en", follow_bad, 0);
    endtask

    initial begin
        t_reset();
        t_idle_flags();
        t_lsb_fcs();
        t_msb_fcs();
        t_fcs_off();
        t_stuff();
        t_invert();
        t_midchange();
        t_underrun();
        t_handshake();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog all-requirements actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule